// File: doc/BRIEF.md
# Spread-Spectrum Phase Rotation Controller

This block turns a fixed-frequency clock into a spread-spectrum clock by slowly rotating the phase-select code of a phase interpolator that sits after the PLL. The frequency offset comes from a triangle generator. Each tick, the triangle's level is treated as a fine phase increment, with 2^FRAC_W fine units equal to one interpolator step. A sigma-delta modulator turns these fine increments into whole rotation steps. The phase code always moves in the decrementing direction, which stretches the period. As a result, the clock only ever slows down and never runs faster than nominal.

Software sets the triangle slope (`step_i`) and the half-period length in ticks (`half_len_i`). For a 30 kHz profile at tick rate f, `half_len_i` is f/60 kHz. A fixed ceiling of 20971 fine units per tick keeps the offset at or below 5000 ppm: with 64 phases and 2^16 fine units per step, 0.005·64·65536 ≈ 20971. `order_i` selects a first-order modulator or a second-order cascaded (MASH 1-1) modulator, so the jitter of the two can be compared.

Top module: `ssc_rot_ctrl`

## Requirements
- R1: While `rst_n` is low, `code_o` is 0 and `rot_o` is 0.
- R2: The triangle level never exceeds 20971 fine units per tick, so the rotation rate stays at or below 20971/65536 steps per tick (5000 ppm of a 64-phase cycle).
- R3: While enabled, the level rises by `step_i` on each of `half_len_i` ticks, capped by R2. It then falls by `step_i` on each of `half_len_i` ticks, floored at 0, and the cycle repeats. A `half_len_i` of 0 acts as 1.
- R4: With `order_i`=0 (first order), each tick the code either holds or decrements by exactly 1 modulo 64. It never increments.
- R5: With `order_i`=1 (MASH 1-1), the modulator output per tick lies in -1..+2, so the code changes per tick by one of +1, 0, -1 or -2 modulo 64.
- R6: While `en_i` is low, the profile and the modulator accumulators are cleared, `code_o` stays constant and `rot_o` is 0.
- R7: `rot_o` is 1 exactly in the cycles in which `code_o` has just changed.
- R8: Over a run of enabled ticks, the net number of code decrements equals the sum of the triangle levels delivered, divided by 65536, within ±3 steps. The level reaches the code two ticks after it is formed.
- R9: `code_o` wraps modulo 64: one decrement from 0 gives 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Update clock; one tick per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Spreading enable; low clears profile and modulator, holds code |
| order_i | input | 1 | 0 = first-order modulator, 1 = MASH 1-1 |
| step_i | input | 16 | Triangle slope in fine units per tick |
| half_len_i | input | 16 | Ticks per rising or falling half of the triangle |
| code_o | output | 6 | Interpolator phase-select code |
| rot_o | output | 1 | Strobe: the code moved this cycle |

## Verification
The hardest situation to reach is the ceiling on the level. It only shows when slope times half-length exceeds 20971, and it is visible only through the long-run rotation rate. The vector table therefore includes runs whose steep slopes cut the triangle flat at the ceiling over many periods. For these runs the bench compares the accumulated decrements against a clipped triangle sum. The same runs, under both orders, also check the per-tick code moves against the allowed sets.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
   // signed coarse step produced by the modulator, range -1..+2
   typedef logic signed [2:0] rot_step_t;
   localparam int unsigned SSC_FRAC_W = 16;
   localparam int unsigned SSC_CODE_W = 6;
endpackage

// File: rtl/ssc_tri_profile.sv
module ssc_tri_profile #(
   parameter int unsigned LVL_W = 16,
   parameter int unsigned CNT_W = 16,
   parameter int unsigned LIMIT = 20971
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [LVL_W-1:0] step_i,
   input  logic [CNT_W-1:0] half_len_i,
   output logic [LVL_W-1:0] level_o
);
   localparam logic [LVL_W:0] LIM_X = LVL_W'(LIMIT);

   logic [CNT_W-1:0] cnt_q;
   logic             dn_q;
   logic [LVL_W:0]   up_sum;
   logic [LVL_W-1:0] nxt_lvl;
   logic             last_tick;

   initial assert (LIMIT < (1 << LVL_W)) else $error("LIMIT exceeds level width");

   assign up_sum    = {1'b0, level_o} + {1'b0, step_i};
   assign last_tick = ({1'b0, cnt_q} + 1'b1) >= {1'b0, half_len_i};

   always_comb begin
      if (!dn_q) begin
         nxt_lvl = (up_sum > LIM_X) ? LIM_X[LVL_W-1:0] : up_sum[LVL_W-1:0];
      end else begin
         nxt_lvl = (level_o > step_i) ? (level_o - step_i) : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         dn_q    <= 1'b0;
         level_o <= '0;
      end else if (!en_i) begin
         cnt_q   <= '0;
         dn_q    <= 1'b0;
         level_o <= '0;
      end else begin
         level_o <= nxt_lvl;
         if (last_tick) begin
            cnt_q <= '0;
            dn_q  <= ~dn_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   p_level_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      level_o <= LIM_X[LVL_W-1:0]);

   p_rise_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !dn_q) |=> (level_o >= $past(level_o)));

   p_fall_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && dn_q) |=> (level_o <= $past(level_o)));
endmodule

// File: rtl/ssc_sdm.sv
module ssc_sdm #(
   parameter int unsigned FRAC_W  = 16,
   parameter bit          MASH_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en_i,
   input  logic                  order_i,
   input  logic [FRAC_W-1:0]     x_i,
   output ssc_pkg::rot_step_t    y_o
);
   import ssc_pkg::*;

   logic [FRAC_W-1:0] acc1_q;
   logic [FRAC_W:0]   sum1;
   rot_step_t         y_nxt;

   initial assert (FRAC_W >= 4) else $error("FRAC_W too small");

   assign sum1 = {1'b0, acc1_q} + {1'b0, x_i};

   generate
      if (MASH_EN) begin : g_mash
         logic [FRAC_W-1:0] acc2_q;
         logic              c2_d_q;
         logic [FRAC_W:0]   sum2;
         assign sum2 = {1'b0, acc2_q} + {1'b0, sum1[FRAC_W-1:0]};
         always_comb begin
            if (order_i)
               y_nxt = rot_step_t'({2'b00, sum1[FRAC_W]}) + rot_step_t'({2'b00, sum2[FRAC_W]})
                     - rot_step_t'({2'b00, c2_d_q});
            else
               y_nxt = rot_step_t'({2'b00, sum1[FRAC_W]});
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc2_q <= '0;
               c2_d_q <= 1'b0;
            end else if (!en_i || !order_i) begin
               acc2_q <= '0;
               c2_d_q <= 1'b0;
            end else begin
               acc2_q <= sum2[FRAC_W-1:0];
               c2_d_q <= sum2[FRAC_W];
            end
         end
      end else begin : g_first
         assign y_nxt = rot_step_t'({2'b00, sum1[FRAC_W]});
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc1_q <= '0;
         y_o    <= '0;
      end else if (!en_i) begin
         acc1_q <= '0;
         y_o    <= '0;
      end else begin
         acc1_q <= sum1[FRAC_W-1:0];
         y_o    <= y_nxt;
      end
   end

   p_first_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !order_i |=> (y_o == 3'sd0 || y_o == 3'sd1));

   p_mash_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (y_o >= -3'sd1) && (y_o <= 3'sd2));
endmodule

// File: rtl/ssc_code_rot.sv
module ssc_code_rot #(
   parameter int unsigned CODE_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_i,
   input  ssc_pkg::rot_step_t y_i,
   output logic [CODE_W-1:0]  code_o,
   output logic               rot_o
);
   logic [CODE_W-1:0] dec;

   initial assert (CODE_W >= 3) else $error("CODE_W too small");

   assign dec = CODE_W'(signed'(y_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o <= '0;
         rot_o  <= 1'b0;
      end else if (!en_i) begin
         rot_o  <= 1'b0;
      end else begin
         code_o <= code_o - dec;
         rot_o  <= (y_i != '0);
      end
   end

   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> ($stable(code_o) && !rot_o));

   p_strobe_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rot_o |-> (code_o != $past(code_o)));

   p_quiet_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rot_o |-> (code_o == $past(code_o)));
endmodule

// File: rtl/ssc_rot_ctrl.sv
module ssc_rot_ctrl #(
   parameter int unsigned FRAC_W  = ssc_pkg::SSC_FRAC_W,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned CODE_W  = ssc_pkg::SSC_CODE_W,
   parameter int unsigned PPM_MAX = 5000,
   parameter bit          MASH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              order_i,
   input  logic [FRAC_W-1:0] step_i,
   input  logic [CNT_W-1:0]  half_len_i,
   output logic [CODE_W-1:0] code_o,
   output logic              rot_o
);
   import ssc_pkg::*;

   // ceiling in fine units per tick: ppm * phases * 2^FRAC_W / 1e6
   localparam longint unsigned LIM_L =
      (longint'(PPM_MAX) * (longint'(1) << CODE_W) * (longint'(1) << FRAC_W)) / 1000000;
   localparam int unsigned LIMIT = int'(LIM_L);

   logic [FRAC_W-1:0] level;
   rot_step_t         y;

   ssc_tri_profile #(.LVL_W(FRAC_W), .CNT_W(CNT_W), .LIMIT(LIMIT)) u_prof (
      .clk(clk), .rst_n(rst_n), .en_i(en_i),
      .step_i(step_i), .half_len_i(half_len_i), .level_o(level));

   ssc_sdm #(.FRAC_W(FRAC_W), .MASH_EN(MASH_EN)) u_sdm (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .order_i(order_i),
      .x_i(level), .y_o(y));

   ssc_code_rot #(.CODE_W(CODE_W)) u_rot (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .y_i(y),
      .code_o(code_o), .rot_o(rot_o));

   p_reset_zero_r1: assert property (@(posedge clk)
      !rst_n |-> (code_o == '0 && !rot_o));
endmodule

// File: tb/ssc_rot_ctrl_tb.sv
module ssc_rot_ctrl_tb;
   localparam int LIM = 20971;
   localparam int NV  = 6;
   // columns: order, step, half_len, ticks
   localparam int VEC [NV][4] = '{
      '{0, 100, 100, 2000},
      '{1, 100, 100, 2000},
      '{0, 500, 100, 1000},
      '{1, 500, 100, 1000},
      '{0,  37, 333, 1998},
      '{1,  37, 333, 1998}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic order = 1'b0;
   logic [15:0] step = '0;
   logic [15:0] half = '0;
   logic [5:0]  code;
   logic        rot;
   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   ssc_rot_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .en_i(en), .order_i(order),
      .step_i(step), .half_len_i(half), .code_o(code), .rot_o(rot));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      en = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(code == 0, "R1 code", code, 0);
      chk(rot == 0, "R1 rot", rot, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // expected decrements: triangle levels L1..L(T-2) summed, divided by 65536
   function automatic int exp_rot(int st, int hl, int t);
      int lvl = 0;
      int cnt = 0;
      bit dn = 0;
      longint s = 0;
      int h = (hl == 0) ? 1 : hl;
      for (int k = 1; k <= t - 2; k++) begin
         if (!dn) lvl = (lvl + st > LIM) ? LIM : lvl + st;
         else     lvl = (lvl > st) ? lvl - st : 0;
         s += lvl;
         if (cnt + 1 >= h) begin cnt = 0; dn = !dn; end
         else cnt++;
      end
      return int'(s / 65536);
   endfunction

   task automatic run_vec(input int ord, input int st, input int hl, input int t);
      int prev;
      int net = 0;
      int bad_mv = 0;
      int bad_st = 0;
      int e;
      do_reset();
      order = ord[0];
      step = 16'(st);
      half = 16'(hl);
      prev = code;
      en = 1'b1;
      for (int k = 0; k < t; k++) begin
         int d;
         @(negedge clk);
         d = (code - prev) & 63;
         if (d >= 32) d -= 64;
         net += d;
         if (ord == 0) begin
            if (!(d == 0 || d == -1)) bad_mv++;
         end else begin
            if (d < -2 || d > 1) bad_mv++;
         end
         if (rot != (d != 0)) bad_st++;
         prev = code;
      end
      e = exp_rot(st, hl, t);
      chk(bad_mv == 0, ord == 0 ? "R4 move set" : "R5 move set", bad_mv, 0);
      chk(bad_st == 0, "R7 strobe", bad_st, 0);
      chk(-net >= e - 3 && -net <= e + 3, "R8/R3/R2 rotation", -net, e);
      chk(-net <= (t * LIM) / 65536 + 3, "R2 ceiling", -net, (t * LIM) / 65536);
      en = 1'b0;
      @(negedge clk);
      prev = code;
      repeat (20) @(negedge clk);
      chk(code == prev && rot == 0, "R6 idle hold", code, prev);
   endtask

   initial begin
      #(20 * 190000);
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      for (int v = 0; v < NV; v++)
         run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

      // R9: first decrement from 0 wraps to 63, full slope at ceiling
      do_reset();
      order = 1'b0; step = 16'd20971; half = 16'd1000;
      en = 1'b1;
      begin
         int first = -1;
         for (int k = 0; k < 20 && first < 0; k++) begin
            @(negedge clk);
            if (code != 0) first = code;
         end
         chk(first == 63, "R9 wrap", first, 63);
      end

      // R6: enable held low with nonzero parameters keeps code still
      do_reset();
      order = 1'b1; step = 16'd3000; half = 16'd5;
      repeat (50) @(negedge clk);
      chk(code == 0 && rot == 0, "R6 disabled", code, 0);

      // R3: half_len 0 behaves as 1 (alternating up/down around step)
      run_vec(0, 4000, 0, 600);

      // R1: reset mid-run returns code to 0
      en = 1'b1; order = 1'b0; step = 16'd20000; half = 16'd50;
      repeat (300) @(negedge clk);
      do_reset();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule